// File: doc/BRIEF.md
# Transmit Descriptor DMA Engine

This block walks a list of transmit descriptors held in system memory and feeds the buffers they describe, one byte at a time, to a MAC transmit port. Each descriptor occupies four 32-bit words: a status word carrying the ownership and error flags, a control word carrying the segment markers, the list-linking mode and the byte count, a buffer pointer, and a link pointer. Software fills a descriptor, sets its ownership flag, and kicks the engine. The engine streams the buffer and then writes the status word back with ownership cleared, which returns the descriptor to software.

A frame may span several descriptors, delimited by first-segment and last-segment markers in the control word. The engine reaches memory through a word-wide request/acknowledge bus with one access outstanding. Software uses a write-only register port to set the list base, to start and stop the engine, and to issue a poll demand that wakes a suspended engine.

When the engine meets a descriptor it does not own, it suspends. It stays suspended until software issues the next poll demand, and then reads the same descriptor again.

Top module: `txdesc_dma`

## Requirements
- R1: While `rst` is high, `mem_req`, `tx_valid` and `tx_last` are all low.
- R2: Writing a 1 to bit 13 of the control register (offset 0x18) starts a stopped engine. Its first memory access is a read of the address last written to the list-base register (offset 0x10).
- R3: If bit 31 of a fetched status word is 0, the engine reads no buffer and sends no byte. It then waits. A write of any value to offset 0x04 makes it read the same descriptor address again.
- R4: For an owned descriptor, the engine sends exactly the number of bytes given in control-word bits [10:0]. It reads them from the word-aligned address in descriptor word 2 (address bits [1:0] are ignored), lowest byte of each memory word first.
- R5: `tx_last` is high only on the final byte of a descriptor whose control-word bit 30 (last segment) is set. It is never high on a segment without that bit.
- R6: After its bytes have been accepted, each descriptor's status word is written back at the descriptor address with bit 31 cleared. Bit 15 of that write is set only when the descriptor is a last segment and `tx_fail` was high during streaming since the most recent descriptor with control-word bit 29 (first segment) set. All other bits of the write are 0.
- R7: The next descriptor address is the list base when control-word bit 25 is set. Otherwise it is descriptor word 3 when bit 24 is set. Otherwise it is the current address plus 16.
- R8: Once `tx_valid` is high, it stays high, and `tx_data` and `tx_last` stay unchanged, until a cycle in which `tx_ready` is high.
- R9: Once `mem_req` is high, it stays high, and `mem_addr` and `mem_we` stay unchanged, until `mem_ack` is seen.
- R10: Clearing control bit 13 lets the engine finish the descriptor it is working on and then stop without fetching another. A poll demand while the engine is stopped causes no memory access.
- R11: A descriptor with a byte count of 0 produces no byte and is still written back.
- R12: The engine never has a memory request and a valid output byte at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data (status word) |
| mem_ack | input | 1 | Access complete; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | MAC accepts the byte this cycle |
| tx_fail | input | 1 | MAC reports a transmit failure |

## Verification
A wrong remaining-length count shows up as a missing or extra byte. The write-back then comes one word early or late, so the byte count and the number of memory reads both fail for that frame within a few cycles. A wrong next-address choice shows up on the bus as the address of the next status read, right after the write-back. A lost error flag or a misplaced last marker stays invisible until the status write or the final byte of the frame. The bench therefore checks each frame's byte stream, its write-back word and the address of the read that follows, all while the bus acknowledge and the byte-ready signal are both held off at irregular intervals.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned LEN_W      = 11;
    localparam int unsigned WORD_BYTES = WORD_W / 8;
    localparam int unsigned DESC_BYTES = 4 * WORD_BYTES;
    localparam int unsigned CNT_W      = $clog2(WORD_BYTES + 1);

    // descriptor bit positions
    localparam int unsigned OWN_BIT   = 31;
    localparam int unsigned ERR_BIT   = 15;
    localparam int unsigned LS_BIT    = 30;
    localparam int unsigned FS_BIT    = 29;
    localparam int unsigned WRAP_BIT  = 25;
    localparam int unsigned CHAIN_BIT = 24;

    // register offsets
    localparam int unsigned OFS_POLL = 'h04;
    localparam int unsigned OFS_BASE = 'h10;
    localparam int unsigned OFS_CTRL = 'h18;
    localparam int unsigned RUN_BIT  = 13;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_RD_CTL,
        ST_RD_BUF,
        ST_RD_LINK,
        ST_FETCH,
        ST_SEND,
        ST_WBACK,
        ST_SUSP
    } eng_state_t;

    typedef struct packed {
        logic             last_seg;
        logic             first_seg;
        logic             wrap;
        logic             chain;
        logic [LEN_W-1:0] len;
    } seg_ctl_t;

    function automatic seg_ctl_t decode_ctl(input logic [WORD_W-1:0] w);
        seg_ctl_t c;
        c.last_seg  = w[LS_BIT];
        c.first_seg = w[FS_BIT];
        c.wrap      = w[WRAP_BIT];
        c.chain     = w[CHAIN_BIT];
        c.len       = w[LEN_W-1:0];
        return c;
    endfunction

    function automatic logic [ADDR_W-1:0] next_desc(
        input seg_ctl_t          c,
        input logic [ADDR_W-1:0] cur,
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-1:0] link
    );
        if (c.wrap)       return base;
        else if (c.chain) return link;
        else              return cur + ADDR_W'(DESC_BYTES);
    endfunction

    function automatic logic [WORD_W-1:0] status_word(input logic err);
        logic [WORD_W-1:0] w;
        w = '0;
        w[ERR_BIT] = err;
        return w;
    endfunction

endpackage

// File: rtl/txd_csr.sv
module txd_csr
    import txdma_pkg::*;
#(
    parameter int unsigned REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [ADDR_W-1:0] list_base,
    output logic              run,
    output logic              poll
);

    always_ff @(posedge clk) begin
        if (rst) begin
            list_base <= '0;
            run       <= 1'b0;
            poll      <= 1'b0;
        end else begin
            poll <= 1'b0;
            if (wr) begin
                if (addr == REG_AW'(OFS_BASE)) list_base <= wdata;
                if (addr == REG_AW'(OFS_CTRL)) run       <= wdata[RUN_BIT];
                if (addr == REG_AW'(OFS_POLL)) poll      <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/txd_byteser.sv
module txd_byteser
    import txdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic              last_seg,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              done
);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  left;
    logic              mark;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            left  <= '0;
            mark  <= 1'b0;
        end else if (load) begin
            shreg <= word;
            left  <= nbytes;
            mark  <= last_seg;
        end else if (tx_valid && tx_ready) begin
            shreg <= shreg >> 8;
            left  <= left - CNT_W'(1);
        end
    end

    assign tx_valid = (left != '0);
    assign tx_data  = shreg[7:0];
    assign tx_last  = mark && (left == CNT_W'(1));
    assign done     = tx_valid && tx_ready && (left == CNT_W'(1));

    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R4
    load_idle_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> !tx_valid);

endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
    import txdma_pkg::*;
#(
    parameter int unsigned REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              tx_fail
);

    eng_state_t        st;
    logic [ADDR_W-1:0] cur, bptr, link_a, list_base;
    seg_ctl_t          ctl;
    logic [LEN_W-1:0]  rem;
    logic              err, run, poll;
    logic [CNT_W-1:0]  chunk;
    logic              ser_load, ser_done, ser_last;

    txd_csr #(.REG_AW(REG_AW)) u_csr (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .list_base (list_base),
        .run       (run),
        .poll      (poll)
    );

    assign chunk    = (rem >= LEN_W'(WORD_BYTES)) ? CNT_W'(WORD_BYTES) : rem[CNT_W-1:0];
    assign ser_load = (st == ST_FETCH) && mem_ack;
    assign ser_last = ctl.last_seg && (rem == LEN_W'(chunk));

    txd_byteser u_ser (
        .clk      (clk),
        .rst      (rst),
        .load     (ser_load),
        .word     (mem_rdata),
        .nbytes   (chunk),
        .last_seg (ser_last),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_last  (tx_last),
        .done     (ser_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cur    <= '0;
            bptr   <= '0;
            link_a <= '0;
            ctl    <= '0;
            rem    <= '0;
            err    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (run) begin
                    cur <= list_base;
                    st  <= ST_RD_STAT;
                end
                ST_RD_STAT: if (mem_ack)
                    st <= mem_rdata[OWN_BIT] ? ST_RD_CTL : ST_SUSP;
                ST_RD_CTL: if (mem_ack) begin
                    ctl <= decode_ctl(mem_rdata);
                    st  <= ST_RD_BUF;
                end
                ST_RD_BUF: if (mem_ack) begin
                    bptr <= {mem_rdata[ADDR_W-1:2], 2'b00};
                    st   <= ST_RD_LINK;
                end
                ST_RD_LINK: if (mem_ack) begin
                    link_a <= mem_rdata;
                    rem    <= ctl.len;
                    if (ctl.first_seg) err <= 1'b0;
                    st <= (ctl.len == '0) ? ST_WBACK : ST_FETCH;
                end
                ST_FETCH: if (mem_ack) begin
                    rem  <= rem - LEN_W'(chunk);
                    bptr <= bptr + ADDR_W'(WORD_BYTES);
                    st   <= ST_SEND;
                end
                ST_SEND: begin
                    if (tx_fail) err <= 1'b1;
                    if (ser_done) st <= (rem == '0) ? ST_WBACK : ST_FETCH;
                end
                ST_WBACK: if (mem_ack) begin
                    cur <= next_desc(ctl, cur, list_base, link_a);
                    st  <= run ? ST_RD_STAT : ST_IDLE;
                end
                ST_SUSP: begin
                    if (!run)      st <= ST_IDLE;
                    else if (poll) st <= ST_RD_STAT;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req  = 1'b1;
        mem_we   = 1'b0;
        mem_addr = cur;
        case (st)
            ST_RD_STAT: mem_addr = cur;
            ST_RD_CTL:  mem_addr = cur + ADDR_W'(WORD_BYTES);
            ST_RD_BUF:  mem_addr = cur + ADDR_W'(2 * WORD_BYTES);
            ST_RD_LINK: mem_addr = cur + ADDR_W'(3 * WORD_BYTES);
            ST_FETCH:   mem_addr = bptr;
            ST_WBACK:   mem_we   = 1'b1;
            default:    mem_req  = 1'b0;
        endcase
    end

    assign mem_wdata = status_word(ctl.last_seg && err);

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6
    wb_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);

    // R12
    bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !mem_req);

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!mem_req && !tx_valid));

endmodule

// File: tb/test_txdesc_dma.sv
module test_txdesc_dma;
    import txdma_pkg::*;

    logic        clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_last, tx_ready, tx_fail;
    logic [7:0]  tx_data;

    txdesc_dma i_txdesc_dma (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .tx_fail(tx_fail)
    );

    int total = 0;
    int bad   = 0;

    // memory model with irregular acknowledge
    logic [31:0] mem [0:255];
    logic        hw;
    logic [31:0] ha, hd;
    int          mcyc = 0, rd_cnt = 0, wr_cnt = 0;
    logic [31:0] last_rd;
    logic [31:0] wl_addr [0:31];
    logic [31:0] wl_data [0:31];

    always @(posedge clk) begin
        mcyc    <= mcyc + 1;
        mem_ack <= 1'b0;
        if (hw) mem[ha[9:2]] <= hd;
        if (mem_req && !mem_ack && (mcyc % 3 != 1)) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[9:2]]   <= mem_wdata;
                wl_addr[wr_cnt % 32] <= mem_addr;
                wl_data[wr_cnt % 32] <= mem_wdata;
                wr_cnt               <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[9:2]];
                last_rd   <= mem_addr;
                rd_cnt    <= rd_cnt + 1;
            end
        end
    end

    // byte sink and handshake monitors, away from the active edge
    int         nb = 0, rcyc = 0, stall_seen = 0, stall_bad = 0, bus_bad = 0;
    logic [7:0] blog [0:255];
    logic       llog [0:255];
    logic       pv = 1'b0, pr = 1'b0, pl = 1'b0, preq = 1'b0, pack = 1'b0;
    logic [7:0] pd;
    logic [31:0] paddr;

    always @(negedge clk) begin
        rcyc = rcyc + 1;
        if (!rst) begin
            if (pv && !pr) begin
                stall_seen = stall_seen + 1;
                if (!tx_valid || tx_data != pd || tx_last != pl) stall_bad = stall_bad + 1;
            end
            if (preq && !pack && (!mem_req || mem_addr != paddr)) bus_bad = bus_bad + 1;
        end
        tx_ready = ((rcyc % 5) != 2) && ((rcyc % 7) != 3);
        if (!rst && tx_valid && tx_ready) begin
            blog[nb % 256] = tx_data;
            llog[nb % 256] = tx_last;
            nb = nb + 1;
        end
        pv = tx_valid; pr = tx_ready; pd = tx_data; pl = tx_last;
        preq = mem_req; pack = mem_ack; paddr = mem_addr;
    end

    // watchdog
    always @(negedge clk) begin
        if (rcyc > 150000) begin
            $display("FAIL watchdog actual=%0d expected=<150000", rcyc);
            $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        hw = 1'b1; ha = a; hd = d;
        @(negedge clk);
        hw = 1'b0;
    endtask

    task automatic csr_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_wr(input int target);
        int t;
        t = 0;
        while (wr_cnt < target && t < 3000) begin
            @(negedge clk);
            t++;
        end
    endtask

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] ctlw(input bit ls, input bit fs, input bit wr, input bit ch, input int len);
        return (32'(ls) << 30) | (32'(fs) << 29) | (32'(wr) << 25) | (32'(ch) << 24) | (32'(len) & 32'h7FF);
    endfunction

    localparam logic [31:0] OWN   = 32'h8000_0000;
    localparam logic [31:0] START = 32'h0000_2000;

    // {byte count, tx_fail during frame}
    localparam logic [11:0] VEC [0:4] = '{
        {11'd1,  1'b0},
        {11'd4,  1'b0},
        {11'd5,  1'b1},
        {11'd11, 1'b0},
        {11'd0,  1'b0}
    };

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        hw = 1'b0; ha = '0; hd = '0; tx_fail = 1'b0;
        tick(5);
        chk(!mem_req && !tx_valid && !tx_last, "R1 outputs quiet in reset",
            {29'd0, mem_req, tx_valid, tx_last}, 0);
        rst = 1'b0;
        tick(10);
        chk(rd_cnt == 0 && !mem_req, "R10 no access before start", rd_cnt, 0);

        for (int a = 'h200; a < 'h280; a += 4)
            host_wr(a, {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)});
        host_wr('h100, 32'h0);
        host_wr('h104, ctlw(1, 1, 1, 0, 0));
        host_wr('h108, 32'h200);
        host_wr('h10C, 32'h0);

        csr_wr(8'h10, 32'h100);
        csr_wr(8'h18, START);
        tick(30);
        chk(rd_cnt == 1 && last_rd == 32'h100, "R2 first fetch at list base", last_rd, 32'h100);
        chk(nb == 0, "R3 unowned descriptor sends no byte", nb, 0);
        chk(rd_cnt == 1, "R3 unowned descriptor reads no buffer", rd_cnt, 1);
        csr_wr(8'h04, 32'h1);
        tick(30);
        chk(rd_cnt == 2 && last_rd == 32'h100, "R3 poll re-reads same descriptor", rd_cnt, 2);

        // single-segment frames on a one-entry ring
        for (int v = 0; v < 5; v++) begin
            int len, n0, r0, w0, mism, lasts, lpos;
            bit fl;
            len = int'(VEC[v][11:1]);
            fl  = VEC[v][0];
            n0 = nb; r0 = rd_cnt; w0 = wr_cnt;
            host_wr('h104, ctlw(1, 1, 1, 0, len));
            host_wr('h100, OWN);
            tx_fail = fl;
            csr_wr(8'h04, 32'h1);
            wait_wr(w0 + 1);
            tick(40);
            tx_fail = 1'b0;
            chk(nb - n0 == len, "R4 byte count", nb - n0, len);
            mism = 0; lasts = 0; lpos = -1;
            for (int i = 0; i < nb - n0; i++) begin
                if (blog[(n0 + i) % 256] != pat(32'h200 + i)) mism++;
                if (llog[(n0 + i) % 256]) begin lasts++; lpos = i; end
            end
            chk(mism == 0, "R4 byte values and order", mism, 0);
            chk(lasts == (len > 0 ? 1 : 0) && (len == 0 || lpos == len - 1),
                "R5 last flag on final byte", lpos, len - 1);
            chk(wr_cnt == w0 + 1 && wl_addr[w0 % 32] == 32'h100 &&
                wl_data[w0 % 32] == (fl ? 32'h8000 : 32'h0),
                "R6 status write-back", wl_data[w0 % 32], fl ? 32'h8000 : 32'h0);
            chk(rd_cnt - r0 == 5 + (len + 3) / 4 && last_rd == 32'h100,
                "R7 wrap returns to list base", rd_cnt - r0, 5 + (len + 3) / 4);
            if (len == 0)
                chk(wr_cnt == w0 + 1 && nb == n0, "R11 zero-length written back", wr_cnt - w0, 1);
        end

        // two-segment frame: chain link then sequential step
        begin
            int n0, r0, w0, mism, lasts, lpos;
            csr_wr(8'h18, 32'h0);
            tick(5);
            host_wr('h140, OWN);
            host_wr('h144, ctlw(0, 1, 0, 1, 3));
            host_wr('h148, 32'h200);
            host_wr('h14C, 32'h180);
            host_wr('h180, OWN);
            host_wr('h184, ctlw(1, 0, 0, 0, 6));
            host_wr('h188, 32'h222);
            host_wr('h18C, 32'h0);
            host_wr('h190, 32'h0);
            n0 = nb; r0 = rd_cnt; w0 = wr_cnt;
            tx_fail = 1'b1;
            csr_wr(8'h10, 32'h140);
            csr_wr(8'h18, START);
            wait_wr(w0 + 2);
            tick(40);
            tx_fail = 1'b0;
            chk(nb - n0 == 9, "R4 two-segment byte count", nb - n0, 9);
            mism = 0; lasts = 0; lpos = -1;
            for (int i = 0; i < nb - n0; i++) begin
                if (blog[(n0 + i) % 256] != (i < 3 ? pat(32'h200 + i) : pat(32'h220 + i - 3))) mism++;
                if (llog[(n0 + i) % 256]) begin lasts++; lpos = i; end
            end
            chk(mism == 0, "R4 buffer address low bits ignored", mism, 0);
            chk(lasts == 1 && lpos == 8, "R5 no last flag on first segment", lpos, 8);
            chk(wl_addr[w0 % 32] == 32'h140 && wl_data[w0 % 32] == 32'h0,
                "R6 non-last segment has no error bit", wl_data[w0 % 32], 0);
            chk(wl_addr[(w0 + 1) % 32] == 32'h180 && wl_data[(w0 + 1) % 32] == 32'h8000,
                "R6 error reported on last segment", wl_data[(w0 + 1) % 32], 32'h8000);
            chk(rd_cnt - r0 == 12 && last_rd == 32'h190, "R7 chain then plus 16", last_rd, 32'h190);
        end

        // poll while stopped
        begin
            int n0, r0;
            csr_wr(8'h18, 32'h0);
            tick(5);
            n0 = nb; r0 = rd_cnt;
            csr_wr(8'h04, 32'h1);
            tick(30);
            chk(rd_cnt == r0 && nb == n0 && !mem_req, "R10 poll ignored while stopped", rd_cnt - r0, 0);
        end

        // stop while a descriptor is in progress
        begin
            int n0, r0, w0, mism;
            host_wr('h1C0, OWN);
            host_wr('h1C4, ctlw(1, 1, 0, 0, 8));
            host_wr('h1C8, 32'h240);
            host_wr('h1CC, 32'h0);
            host_wr('h1D0, OWN);
            host_wr('h1D4, ctlw(1, 1, 0, 0, 4));
            host_wr('h1D8, 32'h200);
            host_wr('h1DC, 32'h0);
            n0 = nb; r0 = rd_cnt; w0 = wr_cnt;
            csr_wr(8'h10, 32'h1C0);
            csr_wr(8'h18, START);
            tick(2);
            csr_wr(8'h18, 32'h0);
            wait_wr(w0 + 1);
            tick(60);
            chk(nb - n0 == 8, "R10 current descriptor completes", nb - n0, 8);
            mism = 0;
            for (int i = 0; i < nb - n0; i++)
                if (blog[(n0 + i) % 256] != pat(32'h240 + i)) mism++;
            chk(mism == 0, "R10 completed bytes correct", mism, 0);
            chk(wr_cnt == w0 + 1 && rd_cnt - r0 == 6 && last_rd == 32'h244,
                "R10 no fetch after stop", last_rd, 32'h244);
        end

        chk(stall_seen > 0 && stall_bad == 0, "R8 byte held while not ready", stall_bad, 0);
        chk(bus_bad == 0, "R9 request held until acknowledge", bus_bad, 0);
        chk(!(mem_req && tx_valid), "R12 bus idle with no byte pending", {31'd0, mem_req}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule